// File: doc/BRIEF.md
# Push-Pull Pulse-Width Modulator with Alternating Output Steering

This block produces the two switch-drive signals for a push-pull converter stage. A free-running counter plays the role of the ramp: it climbs from zero to a programmable top value and then starts again. Two control words compete with it. One is the feedback word from the regulation loop and the other is the dead-time word. A drive can be active only while the ramp lies above both of them. The larger word therefore sets the shorter on-time.

Each time the ramp restarts, one cycle of blanking holds both drives off and toggles a steering flip-flop. Successive pulses are sent to alternate drives, so each drive runs at half the ramp rate. The dead-time compare carries a fixed minimum offset, counted in ramp steps. Because of it, a dead-time word of zero still leaves an off interval in every ramp. The top value, the feedback word and the dead-time word are all captured at each restart and held for the whole ramp.

Top module: `pp_pwm`

## Requirements
- R1: While `rst` is high, both drives are low and `phase_o` is 0. The first ramp after reset starts at value 0 and steers to drive A.
- R2: The ramp runs from 0 up to the captured top value P and then restarts, so one ramp lasts P+1 clock cycles. A top value of 0 gives a ramp of one cycle.
- R3: A drive is active only while the ramp value is strictly greater than the captured feedback word.
- R4: A drive is active only while the ramp value is strictly greater than the captured dead-time word plus `MIN_OFF`. With a dead-time word of 0, ramp values 0 through `MIN_OFF` are always off.
- R5: When both limits are met, the pulse width is set by the larger of the feedback word and (dead-time word + `MIN_OFF`). The pulse is active for ramp values above that bound, up to P.
- R6: In the cycle where the ramp value is 0 (the restart blank), both drives are low.
- R7: `phase_o` toggles at each restart. Drive A (`drv_a_o`) may be active only when `phase_o` is 0, and drive B (`drv_b_o`) only when `phase_o` is 1.
- R8: The two drives are never active in the same cycle.
- R9: The top value, feedback word and dead-time word are sampled only at a restart (and during reset). A change to these inputs in the middle of a ramp has no effect until the next restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Ramp top value P |
| fb_i | input | CNT_W | Feedback (error-amplifier) control word |
| dt_i | input | CNT_W | Dead-time control word |
| drv_a_o | output | 1 | Drive A, active high |
| drv_b_o | output | 1 | Drive B, active high |
| phase_o | output | 1 | Steering state: 0 selects A, 1 selects B |

## Verification
Three things share the restart edge: the wrap of the ramp, the capture of new control words and the steering toggle. A word change that lands exactly in the wrap cycle must therefore take effect for the whole next ramp, while the other drive is selected. The bench provokes this by driving new words in the cycle where the ramp sits at its top value, and also by changing words in mid-ramp. It judges both against a reference ramp model that latches words only at restart. Reset applied during an active pulse is also checked, to confirm the drive drops and that steering restarts at A.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    // Ramp threshold above which a pulse may be on: the larger of the two limits.
    function automatic int unsigned on_bound(int unsigned fb, int unsigned dt,
                                             int unsigned min_off);
        int unsigned dt_lim;
        dt_lim = dt + min_off;
        return (fb > dt_lim) ? fb : dt_lim;
    endfunction

endpackage

// File: rtl/pp_ramp.sv
module pp_ramp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] fb_i,
    input  logic [CNT_W-1:0] dt_i,
    output logic [CNT_W-1:0] ramp_o,
    output logic [CNT_W-1:0] fb_o,
    output logic [CNT_W-1:0] dt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] ramp_q, top_q, fb_q, dt_q;

    assign wrap_o = (ramp_q == top_q);

    always_ff @(posedge clk) begin
        if (rst || wrap_o) begin
            ramp_q <= '0;
            top_q  <= period_i;
            fb_q   <= fb_i;
            dt_q   <= dt_i;
        end else begin
            ramp_q <= ramp_q + 1'b1;
        end
    end

    assign ramp_o = ramp_q;
    assign fb_o   = fb_q;
    assign dt_o   = dt_q;
endmodule

// File: rtl/pp_steer.sv
module pp_steer
    import pp_pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    output phase_e phase_o
);
    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_A;
        else if (tick_i)
            ph_q <= (ph_q == PH_A) ? PH_B : PH_A;
    end

    assign phase_o = ph_q;
endmodule

// File: rtl/pp_gate.sv
module pp_gate
    import pp_pwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int MIN_OFF = 3
) (
    input  logic [CNT_W-1:0] ramp_i,
    input  logic [CNT_W-1:0] fb_i,
    input  logic [CNT_W-1:0] dt_i,
    input  phase_e           phase_i,
    output logic [1:0]       drv_o
);
    logic blank;
    logic open_win;

    assign blank    = (ramp_i == '0);
    assign open_win = int'(ramp_i) > on_bound(int'(fb_i), int'(dt_i), MIN_OFF);

    for (genvar g = 0; g < 2; g++) begin : g_drv
        // NOR of blank, closed window and wrong steering side
        assign drv_o[g] = ~(blank | ~open_win | (int'(phase_i) != g));
    end
endmodule

// File: rtl/pp_pwm.sv
module pp_pwm
    import pp_pwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int MIN_OFF = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] fb_i,
    input  logic [CNT_W-1:0] dt_i,
    output logic             drv_a_o,
    output logic             drv_b_o,
    output logic             phase_o
);
    logic [CNT_W-1:0] ramp_q, fb_q, dt_q;
    logic             wrap;
    phase_e           phase;
    logic [1:0]       drv;

    pp_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk(clk), .rst(rst), .period_i(period_i), .fb_i(fb_i), .dt_i(dt_i),
        .ramp_o(ramp_q), .fb_o(fb_q), .dt_o(dt_q), .wrap_o(wrap)
    );

    pp_steer u_steer (
        .clk(clk), .rst(rst), .tick_i(wrap), .phase_o(phase)
    );

    pp_gate #(.CNT_W(CNT_W), .MIN_OFF(MIN_OFF)) u_gate (
        .ramp_i(ramp_q), .fb_i(fb_q), .dt_i(dt_q), .phase_i(phase), .drv_o(drv)
    );

    assign drv_a_o = drv[0];
    assign drv_b_o = drv[1];
    assign phase_o = phase;
endmodule

// File: rtl/pp_pwm_chk.sv
module pp_pwm_chk #(
    parameter int CNT_W   = 8,
    parameter int MIN_OFF = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] ramp,
    input logic [CNT_W-1:0] fbw,
    input logic [CNT_W-1:0] dtw,
    input logic             drv_a,
    input logic             drv_b,
    input logic             phase
);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drv_a && drv_b));

    a_r6_blank: assert property (@(posedge clk) disable iff (rst)
        (ramp == '0) |-> (!drv_a && !drv_b));

    a_r7_side: assert property (@(posedge clk) disable iff (rst)
        (drv_a |-> !phase) and (drv_b |-> phase));

    a_r3_above_fb: assert property (@(posedge clk) disable iff (rst)
        (drv_a || drv_b) |-> (ramp > fbw));

    a_r4_above_dt: assert property (@(posedge clk) disable iff (rst)
        (drv_a || drv_b) |-> (int'(ramp) > int'(dtw) + MIN_OFF));

    a_r2_ramp_step: assert property (@(posedge clk) disable iff (rst)
        (ramp != '0) |-> (ramp == $past(ramp) + 1'b1));

    a_r9_hold_words: assert property (@(posedge clk) disable iff (rst)
        (ramp != '0) |-> ($stable(fbw) && $stable(dtw)));

    a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
        (ramp != '0) |-> $stable(phase));
endmodule

bind pp_pwm pp_pwm_chk #(.CNT_W(CNT_W), .MIN_OFF(MIN_OFF)) u_pp_pwm_chk (
    .clk(clk), .rst(rst), .ramp(ramp_q), .fbw(fb_q), .dtw(dt_q),
    .drv_a(drv_a_o), .drv_b(drv_b_o), .phase(phase_o)
);

// File: tb/test_pp_pwm.sv
module test_pp_pwm;
    localparam int W       = 8;
    localparam int MINO    = 3;
    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] period = 8'd9;
    logic [W-1:0] fb = 8'd0;
    logic [W-1:0] dt = 8'd0;
    logic         drv_a, drv_b, phase;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // reference model state
    int m_cnt = 0, m_top = 0, m_fb = 0, m_dt = 0;
    bit m_ph = 1'b0;

    pp_pwm #(.CNT_W(W), .MIN_OFF(MINO)) i_pp_pwm (
        .clk(clk), .rst(rst), .period_i(period), .fb_i(fb), .dt_i(dt),
        .drv_a_o(drv_a), .drv_b_o(drv_b), .phase_o(phase)
    );

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (rst || m_cnt == m_top) begin
            if (!rst) m_ph = ~m_ph; else m_ph = 1'b0;
            m_cnt = 0;
            m_top = int'(period);
            m_fb  = int'(fb);
            m_dt  = int'(dt);
        end else begin
            m_cnt++;
        end
    end

    function automatic bit exp_on();
        return (m_cnt != 0) && (m_cnt > m_fb) && (m_cnt > m_dt + MINO);
    endfunction

    function automatic string why();
        if (m_cnt == 0)          return "R6";
        if (m_cnt <= m_fb)       return "R3";
        if (m_cnt <= m_dt + MINO) return "R4";
        return "R7";
    endfunction

    task automatic check(input string tag);
        bit ea, eb;
        ea = exp_on() && !m_ph;
        eb = exp_on() && m_ph;
        n_chk++;
        if (phase !== m_ph) begin
            n_fail++;
            $display("FAIL %s R2 phase: actual %0b expected %0b (ramp %0d)", tag, phase, m_ph, m_cnt);
        end
        n_chk++;
        if (drv_a !== ea || drv_b !== eb) begin
            n_fail++;
            $display("FAIL %s %s drives: actual a=%0b b=%0b expected a=%0b b=%0b (ramp %0d fb %0d dt %0d)",
                     tag, why(), drv_a, drv_b, ea, eb, m_cnt, m_fb, m_dt);
        end
        n_chk++;
        if (drv_a && drv_b) begin
            n_fail++;
            $display("FAIL R8 both drives: actual 1,1 expected not both");
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        rst = 1'b1; period = 8'd9; fb = 8'd2; dt = 8'd0;
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (drv_a !== 1'b0 || drv_b !== 1'b0 || phase !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 reset: actual a=%0b b=%0b ph=%0b expected 0 0 0", drv_a, drv_b, phase);
            end
        end
        rst = 1'b0;
        // R4: zero dead-time word still leaves MIN_OFF off steps
        fb = 8'd0; dt = 8'd0;
        run(40, "R4");
        // R5: feedback word dominates, then dead-time word dominates
        fb = 8'd6; dt = 8'd1;
        run(40, "R5");
        fb = 8'd1; dt = 8'd4;
        run(40, "R5");
        // R2: top value 0 gives a one-cycle ramp, always blank
        period = 8'd0;
        run(12, "R2");
        period = 8'd12; fb = 8'd3; dt = 8'd0;
        run(30, "R2");
        // R9: change words mid-ramp and in the wrap cycle
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            check("R9");
            fb = 8'($urandom_range(0, 14));
            dt = 8'($urandom_range(0, 10));
        end
        // R1: reset during an active run
        fb = 8'd0; dt = 8'd0;
        run(10, "R1");
        rst = 1'b1;
        run(2, "R1");
        rst = 1'b0;
        run(20, "R1");
        // constrained random
        for (int blk = 0; blk < 150; blk++) begin
            period = 8'($urandom_range(0, 24));
            fb     = 8'($urandom_range(0, 26));
            dt     = 8'($urandom_range(0, 22));
            run(int'($urandom_range(5, 40)), "RND");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule